// File: doc/BRIEF.md
# Differential Phase Encoder/Decoder

This block turns a serial bit stream into a stream of 2-bit carrier phase indices and turns a received phase-index stream back into bits. The data chooses how far the phase moves from one symbol to the next, not where the phase sits. A fixed rotation that the channel adds to every received symbol therefore drops out when the decoder takes the difference between neighbouring symbols. A phase index `p` stands for `p * 90` degrees, and all phase arithmetic wraps modulo 4.

One plain input, `mode_quad`, selects the mode. When it is low, the block runs in binary mode: one bit per symbol, and only the increments 0 and 2 occur. When it is high, the block runs in quaternary mode: two bits per symbol, with the first bit of each pair taken as the more significant one, and the increments follow a Gray-ordered table. Both directions share the mode pin. The encoder reads the mode when it accepts a bit. The decoder reads it when it accepts a phase.

All four streams use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A source that raises valid must keep its data stable until the transfer takes place. Each output of the block holds its valid and its data while ready is low. While its output is stalled, each direction lowers the ready of its input, so nothing is lost under back-pressure. Neither ready depends on the valid of its own input.

Top module: `dpc_codec`

## Requirements
- R1: After reset, `tx_phase_valid` and `rx_bit_valid` are low and both input readies are high. The encoder accumulator and the decoder's previous-phase register both start at index 0, so the first transmitted phase equals the first increment. For example, a first binary bit 1 gives phase 2, and a first quaternary pair 11 gives phase 2.
- R2: In binary mode, every accepted bit produces one phase symbol. Bit 1 adds 2 (180 degrees) to the accumulated phase and bit 0 adds 0. The new phase appears on `tx_phase` with `tx_phase_valid` high in the cycle after the bit is accepted.
- R3: In quaternary mode, the encoder produces one symbol for every two accepted bits. The first bit is the MSB of the pair. The increments are: pair 00 adds 0, pair 01 adds 1 (+90), pair 11 adds 2 (180), pair 10 adds 3 (-90).
- R4: In binary mode, each accepted phase `p` produces one output bit equal to bit 1 of `(p - prev) mod 4`, where `prev` is the previously accepted phase. So a difference of 2 or 3 decodes to 1, and a difference of 0 or 1 decodes to 0.
- R5: In quaternary mode, each accepted phase produces two output bits, MSB first, using the inverse of the R3 table: difference 0 gives 00, 1 gives 01, 2 gives 11, and 3 gives 10.
- R6: Adding the same constant to every received phase leaves every decoded bit unchanged, except the bits of the first symbol after reset.
- R7: A mode change takes effect only at a symbol boundary. If `mode_quad` is low in a cycle where the encoder holds the first bit of an unfinished pair and does not accept a new bit, that bit is discarded and adds nothing to the phase.
- R8: While `tx_phase_valid` is high and `tx_phase_ready` is low, `tx_phase` stays unchanged and `tx_bit_ready` is low.
- R9: While `rx_bit_valid` is high and `rx_bit_ready` is low, `rx_bit` stays unchanged and `rx_phase_ready` is low. A quaternary symbol is accepted only when both of its bits can be held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_quad | input | 1 | 0: one bit per symbol, 1: two bits per symbol |
| tx_bit_valid | input | 1 | Serial bit to encode is present |
| tx_bit_ready | output | 1 | Encoder can take a bit |
| tx_bit | input | 1 | Serial bit to encode |
| tx_phase_valid | output | 1 | Encoded phase is present |
| tx_phase_ready | input | 1 | Downstream takes the encoded phase |
| tx_phase | output | 2 | Encoded phase index (multiples of 90 degrees) |
| rx_phase_valid | input | 1 | Received phase index is present |
| rx_phase_ready | output | 1 | Decoder can take a phase |
| rx_phase | input | 2 | Received phase index |
| rx_bit_valid | output | 1 | Decoded bit is present |
| rx_bit_ready | input | 1 | Downstream takes the decoded bit |
| rx_bit | output | 1 | Decoded serial bit |

## Verification
The hardest case to reach is a mode change on the encoder side while half of a pair is held. It takes an odd number of quaternary bits, then one idle cycle with the mode low, then more quaternary bits. The bench builds exactly that sequence and checks that the next phase moves by the increment of the new pair alone. Rotation invariance cannot be seen on a single run. The bench decodes the same phase list twice, the second time shifted by a constant after a fresh reset, and compares the two bit streams from the second symbol on. Long runs with random stalls on both output readies push back-pressure into the middle of quaternary bit pairs. There a decoded symbol must wait until both of its bits fit, and the reference model is compared on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int PHASE_BITS = 2;
  localparam int SYM_BITS_MAX = 2;
  localparam int CNT_W = $clog2(SYM_BITS_MAX + 1);

  typedef logic [PHASE_BITS-1:0] phase_t;
  typedef logic [SYM_BITS_MAX-1:0] pair_t;

  // Gray-ordered pair to phase increment: 00->0, 01->1, 11->2, 10->3
  function automatic phase_t pair_to_step(logic first_bit, logic second_bit);
    return {first_bit, first_bit ^ second_bit};
  endfunction

  // Inverse of pair_to_step; result is {first, second}
  function automatic pair_t step_to_pair(phase_t step);
    return {step[1], step[1] ^ step[0]};
  endfunction

  // Binary mode: a one moves the phase by half a turn
  function automatic phase_t bit_to_step(logic b);
    return {b, 1'b0};
  endfunction

endpackage

// File: rtl/dpc_bit_pairer.sv
module dpc_bit_pairer
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   quad,
  input  logic   in_valid,
  input  logic   in_bit,
  output logic   in_ready,
  output logic   sym_fire,
  output phase_t sym_step,
  input  logic   down_ready
);

  logic held;
  logic held_bit;
  logic take;

  assign in_ready = down_ready;
  assign take     = in_valid && down_ready;
  assign sym_fire = take && (!quad || held);
  assign sym_step = quad ? pair_to_step(held_bit, in_bit) : bit_to_step(in_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_bit <= 1'b0;
    end else if (take) begin
      if (quad && !held) begin
        held     <= 1'b1;
        held_bit <= in_bit;
      end else begin
        held <= 1'b0;
      end
    end else if (!quad) begin
      held <= 1'b0;
    end
  end

endmodule

// File: rtl/dpc_phase_acc.sv
module dpc_phase_acc
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_valid,
  input  phase_t step,
  output logic   step_ready,
  output logic   ph_valid,
  input  logic   ph_ready,
  output phase_t ph
);

  phase_t acc;
  logic   vld;

  assign step_ready = !vld || ph_ready;
  assign ph_valid   = vld;
  assign ph         = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      vld <= 1'b0;
    end else if (step_valid && step_ready) begin
      acc <= acc + step;
      vld <= 1'b1;
    end else if (ph_ready) begin
      vld <= 1'b0;
    end
  end

endmodule

// File: rtl/dpc_phase_diff.sv
module dpc_phase_diff
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   quad,
  input  logic   ph_valid,
  input  phase_t ph,
  output logic   ph_ready,
  input  logic   down_ready,
  output logic   sym_fire,
  output pair_t  sym_bits,
  output logic   sym_two
);

  phase_t prev;
  phase_t delta;

  assign ph_ready = down_ready;
  assign sym_fire = ph_valid && down_ready;
  assign delta    = ph - prev;
  assign sym_two  = quad;
  assign sym_bits = quad ? step_to_pair(delta) : {delta[1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
    end else if (sym_fire) begin
      prev <= ph;
    end
  end

endmodule

// File: rtl/dpc_bit_serializer.sv
module dpc_bit_serializer
  import dpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  pair_t load_bits,
  input  logic  load_two,
  output logic  load_ready,
  output logic  out_valid,
  input  logic  out_ready,
  output logic  out_bit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  pair_t           shreg;
  logic [CNT_W-1:0] cnt;
  logic            pop;

  assign out_valid  = (cnt != '0);
  assign out_bit    = shreg[SYM_BITS_MAX-1];
  assign pop        = out_valid && out_ready;
  assign load_ready = (cnt == '0) || ((cnt == ONE) && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load && load_ready) begin
      shreg <= load_bits;
      cnt   <= load_two ? TWO : ONE;
    end else if (pop) begin
      shreg <= {shreg[SYM_BITS_MAX-2:0], 1'b0};
      cnt   <= cnt - ONE;
    end
  end

endmodule

// File: rtl/dpc_codec.sv
module dpc_codec
  import dpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_quad,
  input  logic       tx_bit_valid,
  output logic       tx_bit_ready,
  input  logic       tx_bit,
  output logic       tx_phase_valid,
  input  logic       tx_phase_ready,
  output logic [1:0] tx_phase,
  input  logic       rx_phase_valid,
  output logic       rx_phase_ready,
  input  logic [1:0] rx_phase,
  output logic       rx_bit_valid,
  input  logic       rx_bit_ready,
  output logic       rx_bit
);

  logic   enc_fire;
  phase_t enc_step;
  logic   enc_room;

  dpc_bit_pairer u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .quad       (mode_quad),
    .in_valid   (tx_bit_valid),
    .in_bit     (tx_bit),
    .in_ready   (tx_bit_ready),
    .sym_fire   (enc_fire),
    .sym_step   (enc_step),
    .down_ready (enc_room)
  );

  dpc_phase_acc u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (enc_fire),
    .step       (enc_step),
    .step_ready (enc_room),
    .ph_valid   (tx_phase_valid),
    .ph_ready   (tx_phase_ready),
    .ph         (tx_phase)
  );

  logic  dec_fire;
  pair_t dec_bits;
  logic  dec_two;
  logic  dec_room;

  dpc_phase_diff u_diff (
    .clk        (clk),
    .rst_n      (rst_n),
    .quad       (mode_quad),
    .ph_valid   (rx_phase_valid),
    .ph         (rx_phase),
    .ph_ready   (rx_phase_ready),
    .down_ready (dec_room),
    .sym_fire   (dec_fire),
    .sym_bits   (dec_bits),
    .sym_two    (dec_two)
  );

  dpc_bit_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (dec_fire),
    .load_bits  (dec_bits),
    .load_two   (dec_two),
    .load_ready (dec_room),
    .out_valid  (rx_bit_valid),
    .out_ready  (rx_bit_ready),
    .out_bit    (rx_bit)
  );

endmodule

// File: rtl/dpc_codec_chk.sv
module dpc_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_quad,
  input logic       tx_bit_valid,
  input logic       tx_bit_ready,
  input logic       tx_bit,
  input logic       tx_phase_valid,
  input logic       tx_phase_ready,
  input logic [1:0] tx_phase,
  input logic       rx_phase_valid,
  input logic       rx_phase_ready,
  input logic [1:0] rx_phase,
  input logic       rx_bit_valid,
  input logic       rx_bit_ready,
  input logic       rx_bit
);

  logic [1:0] seen_tx;
  logic [1:0] last_tx;
  logic [1:0] bin_next;
  logic [1:0] seen_rx;
  logic [1:0] rx_delta;

  assign last_tx  = tx_phase_valid ? tx_phase : seen_tx;
  assign bin_next = last_tx + {tx_bit, 1'b0};
  assign rx_delta = rx_phase - seen_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_tx <= 2'd0;
      seen_rx <= 2'd0;
    end else begin
      if (tx_phase_valid) seen_tx <= tx_phase;
      if (rx_phase_valid && rx_phase_ready) seen_rx <= rx_phase;
    end
  end

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_phase_valid && !tx_phase_ready |=> tx_phase_valid && $stable(tx_phase));

  a_r8_tx_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    tx_phase_valid && !tx_phase_ready |-> !tx_bit_ready);

  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid && !rx_bit_ready |=> rx_bit_valid && $stable(rx_bit));

  a_r9_rx_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_valid && !rx_bit_ready |-> !rx_phase_ready);

  a_r2_binary_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_valid && tx_bit_ready && !mode_quad |=>
      tx_phase_valid && (tx_phase == $past(bin_next)));

  a_r4_binary_decode: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase_valid && rx_phase_ready && !mode_quad |=>
      rx_bit_valid && (rx_bit == $past(rx_delta[1])));

endmodule

bind dpc_codec dpc_codec_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_quad      (mode_quad),
  .tx_bit_valid   (tx_bit_valid),
  .tx_bit_ready   (tx_bit_ready),
  .tx_bit         (tx_bit),
  .tx_phase_valid (tx_phase_valid),
  .tx_phase_ready (tx_phase_ready),
  .tx_phase       (tx_phase),
  .rx_phase_valid (rx_phase_valid),
  .rx_phase_ready (rx_phase_ready),
  .rx_phase       (rx_phase),
  .rx_bit_valid   (rx_bit_valid),
  .rx_bit_ready   (rx_bit_ready),
  .rx_bit         (rx_bit)
);

// File: tb/tb_dpc_codec.sv
`timescale 1ns/1ps
module tb_dpc_codec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       mode_quad = 1'b0;
  logic       ebv = 1'b0, eb = 1'b0, epr = 1'b1;
  logic       dpv = 1'b0, dbr = 1'b1;
  logic [1:0] dph = 2'd0;
  logic       ebr, epv, dpr, dbv, db;
  logic [1:0] eph;

  dpc_codec dut (
    .clk(clk), .rst_n(rst_n), .mode_quad(mode_quad),
    .tx_bit_valid(ebv), .tx_bit_ready(ebr), .tx_bit(eb),
    .tx_phase_valid(epv), .tx_phase_ready(epr), .tx_phase(eph),
    .rx_phase_valid(dpv), .rx_phase_ready(dpr), .rx_phase(dph),
    .rx_bit_valid(dbv), .rx_bit_ready(dbr), .rx_bit(db)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int    m_acc, m_half, m_hb, m_ev, m_prev;
  string m_etag;
  int    dq[$];
  string dtag[$];
  int    eseen[$];
  int    dseen[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_half = 0; m_hb = 0; m_ev = 0; m_prev = 0; m_etag = "R1";
    dq.delete(); dtag.delete(); eseen.delete(); dseen.delete();
  endtask

  function automatic int enc_can_take();
    return (ebv && (!m_ev || epr)) ? 1 : 0;
  endfunction

  function automatic int dec_can_take();
    return (dpv && (dq.size() == 0 || (dq.size() == 1 && dbr))) ? 1 : 0;
  endfunction

  task automatic predict();
    int st;
    int take;
    int dtake;
    int diff;
    if (epv && epr) eseen.push_back(int'(eph));
    if (dbv && dbr) dseen.push_back(int'(db));
    take  = enc_can_take();
    dtake = dec_can_take();
    if (m_ev && epr) m_ev = 0;
    if (take) begin
      if (!mode_quad) begin
        st = eb ? 2 : 0;
        m_acc = (m_acc + st) % 4; m_ev = 1; m_half = 0; m_etag = "R2";
      end else if (!m_half) begin
        m_hb = eb; m_half = 1;
      end else begin
        case (m_hb * 2 + int'(eb))
          0: st = 0;
          1: st = 1;
          3: st = 2;
          default: st = 3;
        endcase
        m_acc = (m_acc + st) % 4; m_ev = 1; m_half = 0; m_etag = "R3";
      end
    end else if (!mode_quad) begin
      m_half = 0;
    end
    if (dq.size() > 0 && dbr) begin
      void'(dq.pop_front());
      void'(dtag.pop_front());
    end
    if (dtake) begin
      diff = (int'(dph) - m_prev + 4) % 4;
      m_prev = int'(dph);
      if (!mode_quad) begin
        dq.push_back(diff >= 2 ? 1 : 0); dtag.push_back("R4");
      end else begin
        dq.push_back((diff == 2 || diff == 3) ? 1 : 0); dtag.push_back("R5");
        dq.push_back((diff == 1 || diff == 2) ? 1 : 0); dtag.push_back("R5");
      end
    end
  endtask

  task automatic compare();
    int exp_dr;
    chk(ebr == (!m_ev || epr), "R8 tx_bit_ready", int'(ebr), int'(!m_ev || epr));
    chk(epv == m_ev[0], {m_etag, " tx_phase_valid"}, int'(epv), m_ev);
    if (m_ev) chk(int'(eph) == m_acc, {m_etag, " tx_phase"}, int'(eph), m_acc);
    exp_dr = (dq.size() == 0 || (dq.size() == 1 && dbr)) ? 1 : 0;
    chk(int'(dpr) == exp_dr, "R9 rx_phase_ready", int'(dpr), exp_dr);
    chk(int'(dbv) == (dq.size() != 0 ? 1 : 0), "R9 rx_bit_valid", int'(dbv), dq.size());
    if (dq.size() != 0) chk(int'(db) == dq[0], {dtag[0], " rx_bit"}, int'(db), dq[0]);
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ebv = 1'b0; dpv = 1'b0; epr = 1'b1; dbr = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    chk(!epv, "R1 tx_phase_valid after reset", int'(epv), 0);
    chk(!dbv, "R1 rx_bit_valid after reset", int'(dbv), 0);
    chk(ebr, "R1 tx_bit_ready after reset", int'(ebr), 1);
    chk(dpr, "R1 rx_phase_ready after reset", int'(dpr), 1);
  endtask

  task automatic drain();
    ebv = 1'b0; dpv = 1'b0; epr = 1'b1; dbr = 1'b1;
    repeat (6) step();
  endtask

  task automatic send_bits(int bits[$], int stall);
    foreach (bits[i]) begin
      ebv = 1'b1; eb = bits[i][0];
      forever begin
        int took;
        epr = ($urandom_range(99) >= stall);
        took = enc_can_take();
        step();
        if (took) break;
      end
    end
    ebv = 1'b0;
  endtask

  task automatic send_phases(int phs[$], int stall);
    foreach (phs[i]) begin
      dpv = 1'b1; dph = 2'(phs[i]);
      forever begin
        int took;
        dbr = ($urandom_range(99) >= stall);
        took = dec_can_take();
        step();
        if (took) break;
      end
    end
    dpv = 1'b0;
  endtask

  task automatic expect_q(int got[$], int exp[$], string tag);
    chk(got.size() == exp.size(), {tag, " count"}, got.size(), exp.size());
    foreach (exp[i]) begin
      if (i < got.size()) chk(got[i] == exp[i], tag, got[i], exp[i]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    int a[$];
    int b[$];
    int p[$];

    // R1: first binary symbol moves from index 0
    do_reset();
    mode_quad = 1'b0;
    send_bits('{1}, 0); drain();
    expect_q(eseen, '{2}, "R1 first binary phase");

    // R1: first quaternary symbol, pair 11
    do_reset();
    mode_quad = 1'b1;
    send_bits('{1, 1}, 0); drain();
    expect_q(eseen, '{2}, "R1 first quad phase");

    // R2: binary encoding
    do_reset();
    mode_quad = 1'b0;
    send_bits('{1, 1, 0, 1, 0}, 0); drain();
    expect_q(eseen, '{2, 0, 0, 2, 2}, "R2 binary phases");

    // R3: Gray pair map, MSB first
    do_reset();
    mode_quad = 1'b1;
    send_bits('{0, 0, 0, 1, 1, 1, 1, 0}, 0); drain();
    expect_q(eseen, '{0, 1, 3, 2}, "R3 quad phases");

    // R7: half pair dropped on mode change
    do_reset();
    mode_quad = 1'b1;
    send_bits('{1}, 0);
    mode_quad = 1'b0; step();
    chk(!epv, "R7 no symbol from dropped half", int'(epv), 0);
    mode_quad = 1'b1;
    send_bits('{0, 1}, 0); drain();
    expect_q(eseen, '{1}, "R7 phase after drop");

    // R8: encoder under back-pressure, both modes
    do_reset();
    mode_quad = 1'b0;
    a.delete();
    for (int i = 0; i < 40; i++) a.push_back($urandom_range(1));
    send_bits(a, 60);
    mode_quad = 1'b1;
    send_bits(a, 60); drain();
    chk(eseen.size() == 60, "R8 symbol count under stall", eseen.size(), 60);

    // R4: binary decoding
    do_reset();
    mode_quad = 1'b0;
    send_phases('{2, 2, 0, 1, 3}, 0); drain();
    expect_q(dseen, '{1, 0, 1, 0, 1}, "R4 binary bits");

    // R5: quaternary decoding, MSB first
    do_reset();
    mode_quad = 1'b1;
    send_phases('{1, 3, 2, 2, 0}, 0); drain();
    expect_q(dseen, '{0, 1, 1, 1, 1, 0, 0, 0, 1, 1}, "R5 quad bits");

    // R9: decoder under back-pressure
    do_reset();
    mode_quad = 1'b1;
    p.delete();
    for (int i = 0; i < 30; i++) p.push_back($urandom_range(3));
    send_phases(p, 60);
    mode_quad = 1'b0;
    send_phases(p, 60); drain();
    chk(dseen.size() == 90, "R9 bit count under stall", dseen.size(), 90);

    // R6: constant rotation cancels
    do_reset();
    mode_quad = 1'b1;
    p = '{3, 1, 2, 0, 0, 3, 2, 1};
    send_phases(p, 30); drain();
    a = dseen;
    do_reset();
    mode_quad = 1'b1;
    foreach (p[i]) p[i] = (p[i] + 1) % 4;
    send_phases(p, 30); drain();
    b = dseen;
    chk(a.size() == b.size(), "R6 run lengths", b.size(), a.size());
    for (int i = 2; i < a.size() && i < b.size(); i++)
      chk(a[i] == b[i], "R6 rotated bit", b[i], a[i]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule